// File: doc/BRIEF.md
# Six-Stage Pipeline Read-After-Write Interlock

This unit guards the operand-read stage of an in-order, single-issue pipeline whose six stages run fetch, decode, operand read, execute, memory and write-back. Each instruction spends one cycle per stage, and each one trails its predecessor by a single stage. Every cycle the unit compares the source registers of the instruction now in operand read against the destination tags held by the execute, memory and write-back stages. From that comparison it decides whether the instruction may move on. When forwarding is enabled, it also names the later stage that must supply each source operand.

The logic is purely combinational, so decisions are made in the same cycle. A static mode input selects forwarding or no forwarding. With forwarding, an ALU result is taken from the output of the execute stage. Load data only exists at the end of the memory stage, so a load that directly precedes its consumer costs one stall cycle. Without forwarding, a consumer waits until its producer has left write-back, because the register file does not write before it reads in the same cycle. While `stall_o` is high, the surrounding pipeline holds fetch, decode and operand read. It also loads a bubble with its write enable cleared into execute, which is what `bubble_o` commands. The unit has no states: the stage tags themselves carry the history. Only the execute stage needs a load flag, because a load in memory or write-back already has its data.

Top module: `hz_interlock`

## Requirements
- R1: When no later stage writes a register that a source names, `stall_o` is 0 and that source's select is 00 (register file).
- R2: With forwarding on, a source that matches a non-load producer in execute gets select 01 (execute output), and that match causes no stall.
- R3: With forwarding on, a source that matches a load in execute raises `stall_o`. An adjacent load-use pair therefore costs exactly one stall cycle.
- R4: With forwarding on, a source matched by the memory stage gets select 10 (memory output) without a stall, whether the producer is a load or an ALU instruction. A dependency two instructions back therefore costs zero stalls.
- R5: With forwarding on, a source matched only by the write-back stage gets select 11 (write-back value).
- R6: When several stages match the same source, the youngest one wins, in the order execute, then memory, then write-back.
- R7: With forwarding off, every select is 00, and a match in execute, memory or write-back raises `stall_o`. An adjacent dependency costs three stall cycles, and a dependency two instructions back costs two.
- R8: Source register 0, and any stage whose write enable is 0, never cause a stall or a nonzero select.
- R9: `bubble_o` is high in exactly the cycles in which `stall_o` is high.
- R10: Each source is resolved on its own: each gets its own select, and `stall_o` is raised if either source needs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_en_i | input | 1 | Static mode: 1 = forwarding, 0 = wait for write-back |
| src_reg_i | input | NUM_SRC x REG_W | Source register numbers of the instruction in operand read |
| ex_dst_i | input | REG_W | Destination of the instruction in execute |
| ex_we_i | input | 1 | Execute-stage instruction writes a register |
| ex_ld_i | input | 1 | Execute-stage instruction is a load |
| mem_dst_i | input | REG_W | Destination of the instruction in memory |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| wb_dst_i | input | REG_W | Destination of the instruction in write-back |
| wb_we_i | input | 1 | Write-back-stage instruction writes a register |
| stall_o | output | 1 | Hold fetch, decode and operand read this cycle |
| bubble_o | output | 1 | Load a no-write bubble into execute this cycle |
| byp_sel_o | output | NUM_SRC x 2 | Per-source operand origin: 00 RF, 01 EX, 10 MEM, 11 WB |

## Verification
The bench runs short instruction sequences through a cycle model of the pipeline that obeys the stall output. It counts stall cycles for load-use and ALU-use pairs, in both modes and at distances one and two. A unit that forgot load latency would give zero stalls where one is due. A unit that treated the write-back stage as already written would give two stalls instead of three. Direct probes then check three more cases. When all three stages match, the youngest must be selected, and a design that reverses the priority would forward stale data. Register 0 and cleared write enables must never cause a hazard; a design that ignores them would stall for nothing. Finally, the two sources are given different producers to confirm that each source gets its own select.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        BYP_RF  = 2'b00,
        BYP_EX  = 2'b01,
        BYP_MEM = 2'b10,
        BYP_WB  = 2'b11
    } byp_sel_e;

    localparam int LATER_STAGES = 3;

endpackage

// File: rtl/hz_prod_match.sv
module hz_prod_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_i,
    input  logic [REG_W-1:0] ex_dst_i,
    input  logic             ex_we_i,
    input  logic [REG_W-1:0] mem_dst_i,
    input  logic             mem_we_i,
    input  logic [REG_W-1:0] wb_dst_i,
    input  logic             wb_we_i,
    output logic             hit_ex_o,
    output logic             hit_mem_o,
    output logic             hit_wb_o
);

    // Register 0 is hard-wired, so it never names a real producer.
    logic live;

    always_comb begin
        live      = (src_i != '0);
        hit_ex_o  = live && ex_we_i  && (ex_dst_i  == src_i);
        hit_mem_o = live && mem_we_i && (mem_dst_i == src_i);
        hit_wb_o  = live && wb_we_i  && (wb_dst_i  == src_i);
    end

endmodule

// File: rtl/hz_src_policy.sv
module hz_src_policy
    import hz_pkg::*;
(
    input  logic     fwd_en_i,
    input  logic     hit_ex_i,
    input  logic     hit_mem_i,
    input  logic     hit_wb_i,
    input  logic     ex_ld_i,
    output byp_sel_e sel_o,
    output logic     hold_o
);

    always_comb begin
        sel_o  = BYP_RF;
        hold_o = 1'b0;
        if (!fwd_en_i) begin
            // No bypass: wait until the producer has left write-back.
            hold_o = hit_ex_i || hit_mem_i || hit_wb_i;
        end else if (hit_ex_i) begin
            // Youngest producer. Load data is not ready until end of memory.
            if (ex_ld_i) begin
                hold_o = 1'b1;
            end else begin
                sel_o = BYP_EX;
            end
        end else if (hit_mem_i) begin
            sel_o = BYP_MEM;
        end else if (hit_wb_i) begin
            sel_o = BYP_WB;
        end
    end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                            fwd_en_i,
    input  logic [NUM_SRC-1:0][REG_W-1:0]   src_reg_i,
    input  logic [REG_W-1:0]                ex_dst_i,
    input  logic                            ex_we_i,
    input  logic                            ex_ld_i,
    input  logic [REG_W-1:0]                mem_dst_i,
    input  logic                            mem_we_i,
    input  logic [REG_W-1:0]                wb_dst_i,
    input  logic                            wb_we_i,
    output logic                            stall_o,
    output logic                            bubble_o,
    output logic [NUM_SRC-1:0][1:0]         byp_sel_o
);

    localparam int SEL_W = $bits(byp_sel_e);

    logic [NUM_SRC-1:0] hold_vec;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic     hit_ex;
        logic     hit_mem;
        logic     hit_wb;
        byp_sel_e sel;

        hz_prod_match #(.REG_W(REG_W)) u_match (
            .src_i     (src_reg_i[g]),
            .ex_dst_i  (ex_dst_i),
            .ex_we_i   (ex_we_i),
            .mem_dst_i (mem_dst_i),
            .mem_we_i  (mem_we_i),
            .wb_dst_i  (wb_dst_i),
            .wb_we_i   (wb_we_i),
            .hit_ex_o  (hit_ex),
            .hit_mem_o (hit_mem),
            .hit_wb_o  (hit_wb)
        );

        hz_src_policy u_policy (
            .fwd_en_i  (fwd_en_i),
            .hit_ex_i  (hit_ex),
            .hit_mem_i (hit_mem),
            .hit_wb_i  (hit_wb),
            .ex_ld_i   (ex_ld_i),
            .sel_o     (sel),
            .hold_o    (hold_vec[g])
        );

        assign byp_sel_o[g] = SEL_W'(sel);
    end

    // Hold the front end and inject a no-write bubble into execute together.
    always_comb begin
        stall_o  = |hold_vec;
        bubble_o = stall_o;
    end

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input logic                          fwd_en_i,
    input logic [NUM_SRC-1:0][REG_W-1:0] src_reg_i,
    input logic [REG_W-1:0]              ex_dst_i,
    input logic                          ex_we_i,
    input logic                          ex_ld_i,
    input logic [REG_W-1:0]              mem_dst_i,
    input logic                          mem_we_i,
    input logic [REG_W-1:0]              wb_dst_i,
    input logic                          wb_we_i,
    input logic                          stall_i,
    input logic                          bubble_i,
    input logic [NUM_SRC-1:0][1:0]       byp_sel_i
);

    always_comb begin
        a_r9_bubble_tracks_stall: assert (bubble_i == stall_i)
            else $error("R9 bubble and stall disagree");
        if (fwd_en_i && !(ex_we_i && ex_ld_i)) begin
            a_r2_fwd_no_alu_stall: assert (!stall_i)
                else $error("R2 stall without a load in execute");
        end
        if (src_reg_i == '0) begin
            a_r8_zero_src_no_stall: assert (!stall_i && byp_sel_i == '0)
                else $error("R8 register 0 caused a hazard");
        end
        for (int k = 0; k < NUM_SRC; k++) begin
            if (!fwd_en_i) begin
                a_r7_nofwd_rf_only: assert (byp_sel_i[k] == 2'b00)
                    else $error("R7 bypass used with forwarding off");
                if (src_reg_i[k] != '0 && mem_we_i && mem_dst_i == src_reg_i[k]) begin
                    a_r7_nofwd_mem_stall: assert (stall_i)
                        else $error("R7 missed stall on memory-stage producer");
                end
            end else if (src_reg_i[k] != '0 && ex_we_i && ex_ld_i
                         && ex_dst_i == src_reg_i[k]) begin
                a_r3_load_use_stall: assert (stall_i)
                    else $error("R3 load-use not stalled");
            end
            if (byp_sel_i[k] == 2'b01) begin
                a_r6_ex_sel_valid: assert (ex_we_i && ex_dst_i == src_reg_i[k] && !ex_ld_i)
                    else $error("R6 execute select without an ALU producer");
            end
        end
    end

endmodule

bind hz_interlock hz_interlock_chk #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_chk (
    .fwd_en_i  (fwd_en_i),
    .src_reg_i (src_reg_i),
    .ex_dst_i  (ex_dst_i),
    .ex_we_i   (ex_we_i),
    .ex_ld_i   (ex_ld_i),
    .mem_dst_i (mem_dst_i),
    .mem_we_i  (mem_we_i),
    .wb_dst_i  (wb_dst_i),
    .wb_we_i   (wb_we_i),
    .stall_i   (stall_o),
    .bubble_i  (bubble_o),
    .byp_sel_i (byp_sel_o)
);

// File: tb/tb_hz_interlock.sv
module tb_hz_interlock;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            fwd_en;
    logic [1:0][4:0] src;
    logic [4:0]      ex_dst, mem_dst, wb_dst;
    logic            ex_we, ex_ld, mem_we, wb_we;
    logic            stall, bubble;
    logic [1:0][1:0] sel;

    hz_interlock #(.REG_W(5), .NUM_SRC(2)) dut (
        .fwd_en_i(fwd_en), .src_reg_i(src),
        .ex_dst_i(ex_dst), .ex_we_i(ex_we), .ex_ld_i(ex_ld),
        .mem_dst_i(mem_dst), .mem_we_i(mem_we),
        .wb_dst_i(wb_dst), .wb_we_i(wb_we),
        .stall_o(stall), .bubble_o(bubble), .byp_sel_o(sel)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stages();
        src = '0; ex_dst = 0; ex_we = 0; ex_ld = 0;
        mem_dst = 0; mem_we = 0; wb_dst = 0; wb_we = 0;
    endtask

    task automatic settle();
        @(posedge clk); #2;
    endtask

    // Program memory for the cycle model
    logic [4:0] p_dst [4];
    logic       p_we  [4];
    logic       p_ld  [4];
    logic [4:0] p_rs1 [4];
    logic [4:0] p_rs2 [4];
    int         p_n;

    task automatic set_instr(input int i, input logic [4:0] d, input logic w,
                             input logic l, input logic [4:0] a, input logic [4:0] b);
        p_dst[i] = d; p_we[i] = w; p_ld[i] = l; p_rs1[i] = a; p_rs2[i] = b;
    endtask

    // Runs the program through a model that obeys stall; returns stall cycles.
    task automatic run_prog(input logic fwd, input int exp_stalls, input string req);
        int of_i = 0; int stalls = 0; int guard = 0;
        logic [4:0] e_d = 0, m_d = 0, w_d = 0;
        logic e_w = 0, m_w = 0, w_w = 0, e_l = 0;
        logic st;
        fwd_en = fwd;
        @(posedge clk);
        while (of_i < p_n && guard < 50) begin
            #1;
            src[0] = p_rs1[of_i]; src[1] = p_rs2[of_i];
            ex_dst = e_d; ex_we = e_w; ex_ld = e_l;
            mem_dst = m_d; mem_we = m_w; wb_dst = w_d; wb_we = w_w;
            #2;
            st = stall;
            chk({req, " bubble"}, int'(bubble), int'(st));
            @(posedge clk);
            w_d = m_d; w_w = m_w; m_d = e_d; m_w = e_w;
            if (st) begin
                stalls++;
                e_d = 0; e_w = 0; e_l = 0;
            end else begin
                e_d = p_dst[of_i]; e_w = p_we[of_i]; e_l = p_ld[of_i];
                of_i++;
            end
            guard++;
        end
        chk(req, stalls, exp_stalls);
        #1; clear_stages();
    endtask

    task automatic t_idle();
        clear_stages(); fwd_en = 1; src[0] = 5'd3; src[1] = 5'd4; settle();
        chk("R1 idle stall", int'(stall), 0);
        chk("R1 idle sel0", int'(sel[0]), 0);
        chk("R1 idle sel1", int'(sel[1]), 0);
    endtask

    task automatic t_fwd_selects();
        clear_stages(); fwd_en = 1; src[0] = 5'd5;
        ex_dst = 5; ex_we = 1; settle();
        chk("R2 ex select", int'(sel[0]), 1);
        chk("R2 no stall", int'(stall), 0);
        ex_ld = 1; settle();
        chk("R3 load in ex stalls", int'(stall), 1);
        chk("R9 bubble with stall", int'(bubble), 1);
        clear_stages(); src[0] = 5'd5; mem_dst = 5; mem_we = 1; settle();
        chk("R4 mem select", int'(sel[0]), 2);
        chk("R4 mem no stall", int'(stall), 0);
        clear_stages(); src[0] = 5'd5; wb_dst = 5; wb_we = 1; settle();
        chk("R5 wb select", int'(sel[0]), 3);
        clear_stages();
    endtask

    task automatic t_priority();
        clear_stages(); fwd_en = 1; src[0] = 5'd9;
        ex_dst = 9; ex_we = 1; mem_dst = 9; mem_we = 1; wb_dst = 9; wb_we = 1; settle();
        chk("R6 ex beats mem/wb", int'(sel[0]), 1);
        ex_we = 0; settle();
        chk("R6 mem beats wb", int'(sel[0]), 2);
        clear_stages();
    endtask

    task automatic t_ignored();
        clear_stages(); fwd_en = 1; src[0] = 5'd0; src[1] = 5'd0;
        ex_dst = 0; ex_we = 1; ex_ld = 1; settle();
        chk("R8 reg0 load no stall", int'(stall), 0);
        chk("R8 reg0 sel", int'(sel[0]), 0);
        src[0] = 5'd7; ex_dst = 7; ex_we = 0; mem_dst = 7; wb_dst = 7; settle();
        chk("R8 we clear no stall", int'(stall), 0);
        chk("R8 we clear sel", int'(sel[0]), 0);
        fwd_en = 0; settle();
        chk("R8 we clear nofwd", int'(stall), 0);
        clear_stages();
    endtask

    task automatic t_nofwd();
        clear_stages(); fwd_en = 0; src[1] = 5'd6; wb_dst = 6; wb_we = 1; settle();
        chk("R7 wb producer stalls", int'(stall), 1);
        chk("R7 sel rf", int'(sel[1]), 0);
        clear_stages();
    endtask

    task automatic t_two_src();
        clear_stages(); fwd_en = 1; src[0] = 5'd2; src[1] = 5'd3;
        ex_dst = 2; ex_we = 1; mem_dst = 3; mem_we = 1; settle();
        chk("R10 src0 ex", int'(sel[0]), 1);
        chk("R10 src1 mem", int'(sel[1]), 2);
        ex_dst = 3; ex_ld = 1; mem_dst = 2; settle();
        chk("R10 src1 load stalls", int'(stall), 1);
        clear_stages();
    endtask

    task automatic t_sequences();
        // load r5 ; r2 = r5 + r7
        p_n = 2;
        set_instr(0, 5, 1, 1, 0, 0); set_instr(1, 2, 1, 0, 5, 7);
        run_prog(1, 1, "R3 load-use fwd");
        run_prog(0, 3, "R7 load-use nofwd");
        // r5 = r1 + r3 ; r2 = r5 + r7
        set_instr(0, 5, 1, 0, 1, 3);
        run_prog(1, 0, "R2 alu-use fwd");
        run_prog(0, 3, "R7 alu-use nofwd");
        // r1 = ..; r6 = ..; r4 = r1 + r5
        p_n = 3;
        set_instr(0, 1, 1, 0, 2, 3); set_instr(1, 6, 1, 0, 7, 8); set_instr(2, 4, 1, 0, 1, 5);
        run_prog(1, 0, "R4 distance-two alu fwd");
        run_prog(0, 2, "R7 distance-two nofwd");
        set_instr(0, 1, 1, 1, 0, 0);
        run_prog(1, 0, "R4 distance-two load fwd");
        // write to r0 then read r0
        p_n = 2;
        set_instr(0, 0, 1, 1, 0, 0); set_instr(1, 2, 1, 0, 0, 0);
        run_prog(0, 0, "R8 reg0 sequence");
    endtask

    initial begin
        clear_stages(); fwd_en = 1;
        t_idle();
        t_fwd_selects();
        t_priority();
        t_ignored();
        t_nofwd();
        t_two_src();
        t_sequences();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule